// File: doc/BRIEF.md
# Quad-Data-Rate Burst SRAM Model

A synthesizable behavioural model of a burst SRAM with a dedicated read-data output and a dedicated write-data input. One address bus carries both kinds of request, taking turns. Every address names a block of four words, and each access moves all four words in order over two input-clock periods, one word per half period.

The model runs on a single internal clock at twice the input-clock rate. The `slot` output tells the host where it stands in the repeating four-beat frame. Slots 0 and 2 stand for rising edges of the input clock, and slots 1 and 3 for rising edges of its complement. Read requests are taken in slot 0 and write requests in slot 2. Write data follows its address over the next four beats. The whole burst is stored in one step on the last of those beats. A bypass path makes a read see a write whose address came first even when the two meet on that step. A static input picks a read latency of one or one and a half input-clock periods.

Top module: `qdr_burst_sram`

## Requirements
- R1: After reset `slot` reads 0 and then steps 0,1,2,3,0,... by one on every clock edge.
- R2: A read request is taken at an edge in slot 0 when `rd_sel_n` is low. With `rd_sel_n` high in slot 0 no burst is returned and `rvalid` stays low.
- R3: A write request is taken at an edge in slot 2 when `wr_sel_n` is low. Its data words 0,1,2,3 are taken at the next four edges (slots 3,0,1,2). With `wr_sel_n` high nothing is written.
- R4: `addr` selects a four-word block. A read returns the block's words 0,1,2,3 on four beats in that order.
- R5: For a read taken at edge E, word 0 is on `rdata` with `rvalid` high after edge E+3 when `lat_short` is 0, and after edge E+2 when `lat_short` is 1.
- R6: Each read request drives `rvalid` high for exactly four beats. Back-to-back reads give an unbroken run of `rvalid`.
- R7: While `rvalid` is low, `rdata` keeps its last value.
- R8: `wbe_n` is an active-low byte enable sampled with each write word. Bit b covers `wdata[8b+7:8b]`. A byte whose bit is 1 keeps its stored value.
- R9: A read taken in the frame after a write to the same block returns the new data, with masked bytes merged, in both latency modes.
- R10: A read and a write in the same frame act independently. A read of the block that the same frame's write targets returns the old contents.
- R11: While `rst` is high, `rvalid` is 0, `rdata` is 0 and `slot` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, two beats per input-clock period |
| rst | input | 1 | Synchronous active-high reset |
| lat_short | input | 1 | Static latency select: 0 gives 1.5 periods, 1 gives 1 period |
| rd_sel_n | input | 1 | Active-low read request, sampled in slot 0 |
| wr_sel_n | input | 1 | Active-low write request, sampled in slot 2 |
| addr | input | AW | Block address shared by reads and writes |
| wdata | input | 8*NB | Write data word, one per beat |
| wbe_n | input | NB | Active-low byte enables for the current write word |
| slot | output | 2 | Beat position in the four-beat frame |
| rdata | output | 8*NB | Registered read data word |
| rvalid | output | 1 | High on the four beats that carry a read burst |

## Verification
Assertions check on every cycle that the slot advances by one, that a write burst is committed exactly four beats after its address, that the first read beat follows its request by the latency the mode selects, that read beats run 0 to 3 without gaps or overruns, and that `rdata` holds while `rvalid` is low. The data itself can only be shown by the bench's scenarios. These cover word order within a block, byte masking, silent requests, and the bypass merge when a read meets the commit of an older write. They also cover a read that must not see a write from its own frame.

// File: rtl/qdr_pkg.sv
package qdr_pkg;

    localparam int BURST_LEN  = 4;
    localparam int BEAT_W     = $clog2(BURST_LEN);
    localparam int BYTE_W     = 8;

    // Position inside the four-beat frame; even slots are rising input-clock edges
    typedef enum logic [1:0] {
        SL_RD_ADDR = 2'd0,
        SL_RD_FALL = 2'd1,
        SL_WR_ADDR = 2'd2,
        SL_WR_FALL = 2'd3
    } slot_t;

    // Write word index captured in a given slot (slot 3 -> 0 ... slot 2 -> 3)
    function automatic logic [BEAT_W-1:0] wr_beat_of(slot_t s);
        return BEAT_W'(int'(s) + 1);
    endfunction

    // Slot in which the first read word is registered onto the output
    function automatic slot_t first_read_slot(logic short_lat);
        return short_lat ? SL_WR_ADDR : SL_WR_FALL;
    endfunction

endpackage

// File: rtl/qdr_slot_timer.sv
module qdr_slot_timer
    import qdr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output slot_t slot
);

    always_ff @(posedge clk) begin
        if (rst) slot <= SL_RD_ADDR;
        else     slot <= slot_t'(2'(slot + 2'd1));
    end

    // R1: one step per edge, wrapping after slot 3
    a_r1_slot_step: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> slot == slot_t'(2'($past(slot) + 2'd1)));

endmodule

// File: rtl/qdr_write_collect.sv
module qdr_write_collect
    import qdr_pkg::*;
#(
    parameter int AW = 4,
    parameter int NB = 2,
    localparam int W = NB * BYTE_W
) (
    input  logic                             clk,
    input  logic                             rst,
    input  slot_t                            slot,
    input  logic                             wr_sel_n,
    input  logic [AW-1:0]                    addr,
    input  logic [W-1:0]                     wdata,
    input  logic [NB-1:0]                    wbe_n,
    output logic                             commit,
    output logic [AW-1:0]                    commit_addr,
    output logic [BURST_LEN-1:0][W-1:0]      commit_data,
    output logic [BURST_LEN-1:0][NB-1:0]     commit_be_n
);

    logic                              pend;
    logic [AW-1:0]                     pend_addr;
    logic [BURST_LEN-2:0][W-1:0]       beat_d;
    logic [BURST_LEN-2:0][NB-1:0]      beat_be;
    logic                              at_wr;

    assign at_wr = (slot == SL_WR_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend      <= 1'b0;
            pend_addr <= '0;
        end else if (at_wr) begin
            pend      <= !wr_sel_n;
            pend_addr <= addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!at_wr) begin
            beat_d[wr_beat_of(slot)]  <= wdata;
            beat_be[wr_beat_of(slot)] <= wbe_n;
        end
    end

    assign commit      = at_wr && pend;
    assign commit_addr = pend_addr;

    // Last word is taken straight from the inputs on the commit edge
    for (genvar k = 0; k < BURST_LEN; k++) begin : g_word
        if (k == BURST_LEN - 1) begin : g_live
            assign commit_data[k] = wdata;
            assign commit_be_n[k] = wbe_n;
        end else begin : g_held
            assign commit_data[k] = beat_d[k];
            assign commit_be_n[k] = beat_be[k];
        end
    end

    // R3: a burst is stored exactly four beats after its address was taken
    a_r3_commit_delay: assert property (@(posedge clk) disable iff (rst)
        commit |-> $past(slot == SL_WR_ADDR && !wr_sel_n, 4));

endmodule

// File: rtl/qdr_burst_array.sv
module qdr_burst_array
    import qdr_pkg::*;
#(
    parameter int AW = 4,
    parameter int NB = 2,
    localparam int W     = NB * BYTE_W,
    localparam int WORDS = BURST_LEN << AW
) (
    input  logic                          clk,
    input  logic                          commit,
    input  logic [AW-1:0]                 commit_addr,
    input  logic [BURST_LEN-1:0][W-1:0]   commit_data,
    input  logic [BURST_LEN-1:0][NB-1:0]  commit_be_n,
    input  logic [AW+BEAT_W-1:0]          rd_word,
    output logic [W-1:0]                  rd_data
);

    logic [W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (commit) begin
            for (int k = 0; k < BURST_LEN; k++) begin
                for (int b = 0; b < NB; b++) begin
                    if (!commit_be_n[k][b])
                        mem[{commit_addr, BEAT_W'(k)}][b*BYTE_W +: BYTE_W] <=
                            commit_data[k][b*BYTE_W +: BYTE_W];
                end
            end
        end
    end

    assign rd_data = mem[rd_word];

endmodule

// File: rtl/qdr_read_sched.sv
module qdr_read_sched
    import qdr_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  slot_t                    slot,
    input  logic                     lat_short,
    input  logic                     rd_sel_n,
    input  logic [AW-1:0]            addr,
    output logic                     fire,
    output logic                     first_beat,
    output logic [AW+BEAT_W-1:0]     rd_word
);

    logic               req_v;
    logic [AW-1:0]      req_a;
    logic               out_v;
    logic [AW-1:0]      out_a;
    logic [BEAT_W-1:0]  out_beat;
    logic               start;

    assign start      = req_v && (slot == first_read_slot(lat_short));
    assign fire       = start || out_v;
    assign first_beat = start;
    assign rd_word    = start ? {req_a, BEAT_W'(0)} : {out_a, out_beat};

    always_ff @(posedge clk) begin
        if (rst) begin
            req_v    <= 1'b0;
            req_a    <= '0;
            out_v    <= 1'b0;
            out_a    <= '0;
            out_beat <= '0;
        end else begin
            if (slot == SL_RD_ADDR) begin
                req_v <= !rd_sel_n;
                req_a <= addr;
            end else if (start) begin
                req_v <= 1'b0;
            end
            if (start) begin
                out_v    <= 1'b1;
                out_a    <= req_a;
                out_beat <= BEAT_W'(1);
            end else if (out_v) begin
                out_beat <= out_beat + BEAT_W'(1);
                if (out_beat == BEAT_W'(BURST_LEN - 1)) out_v <= 1'b0;
            end
        end
    end

    // R5: first word leaves 2 or 3 beats after its request, by mode
    a_r5_short_lat: assert property (@(posedge clk) disable iff (rst)
        (start && lat_short) |-> $past(slot == SL_RD_ADDR && !rd_sel_n, 2));
    a_r5_full_lat: assert property (@(posedge clk) disable iff (rst)
        (start && !lat_short) |-> $past(slot == SL_RD_ADDR && !rd_sel_n, 3));
    // R6: a new burst never cuts into one still being sent
    a_r6_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(start && out_v));

endmodule

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram
    import qdr_pkg::*;
#(
    parameter int AW = 4,
    parameter int NB = 2,
    localparam int W = NB * BYTE_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           lat_short,
    input  logic           rd_sel_n,
    input  logic           wr_sel_n,
    input  logic [AW-1:0]  addr,
    input  logic [W-1:0]   wdata,
    input  logic [NB-1:0]  wbe_n,
    output logic [1:0]     slot,
    output logic [W-1:0]   rdata,
    output logic           rvalid
);

    slot_t                          cur_slot;
    logic                           commit;
    logic [AW-1:0]                  commit_addr;
    logic [BURST_LEN-1:0][W-1:0]    commit_data;
    logic [BURST_LEN-1:0][NB-1:0]   commit_be_n;
    logic                           fire;
    logic                           first_beat;
    logic [AW+BEAT_W-1:0]           rd_word;
    logic [W-1:0]                   mem_rd;
    logic [W-1:0]                   byp_word;
    logic                           byp;
    logic [BEAT_W-1:0]              rbeat_q;

    qdr_slot_timer u_timer (
        .clk  (clk),
        .rst  (rst),
        .slot (cur_slot)
    );

    qdr_write_collect #(.AW(AW), .NB(NB)) u_wcol (
        .clk         (clk),
        .rst         (rst),
        .slot        (cur_slot),
        .wr_sel_n    (wr_sel_n),
        .addr        (addr),
        .wdata       (wdata),
        .wbe_n       (wbe_n),
        .commit      (commit),
        .commit_addr (commit_addr),
        .commit_data (commit_data),
        .commit_be_n (commit_be_n)
    );

    qdr_burst_array #(.AW(AW), .NB(NB)) u_array (
        .clk         (clk),
        .commit      (commit),
        .commit_addr (commit_addr),
        .commit_data (commit_data),
        .commit_be_n (commit_be_n),
        .rd_word     (rd_word),
        .rd_data     (mem_rd)
    );

    qdr_read_sched #(.AW(AW)) u_rsched (
        .clk        (clk),
        .rst        (rst),
        .slot       (cur_slot),
        .lat_short  (lat_short),
        .rd_sel_n   (rd_sel_n),
        .addr       (addr),
        .fire       (fire),
        .first_beat (first_beat),
        .rd_word    (rd_word)
    );

    // Coherency: first word of a short-latency read meets the commit of the older write
    assign byp = first_beat && commit && (commit_addr == rd_word[AW+BEAT_W-1:BEAT_W]);

    for (genvar b = 0; b < NB; b++) begin : g_byp
        assign byp_word[b*BYTE_W +: BYTE_W] = commit_be_n[0][b] ?
            mem_rd[b*BYTE_W +: BYTE_W] : commit_data[0][b*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata   <= '0;
            rvalid  <= 1'b0;
            rbeat_q <= '0;
        end else begin
            rvalid <= fire;
            if (fire) begin
                rdata   <= byp ? byp_word : mem_rd;
                rbeat_q <= rd_word[BEAT_W-1:0];
            end
        end
    end

    assign slot = cur_slot;

    // R7: output word is held between bursts
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !rvalid |-> $stable(rdata));
    // R6: beats start at word 0, advance by one, and end on the last word
    a_r6_first_word: assert property (@(posedge clk) disable iff (rst)
        $rose(rvalid) |-> rbeat_q == '0);
    a_r6_next_word: assert property (@(posedge clk) disable iff (rst)
        (rvalid && $past(rvalid)) |-> rbeat_q == BEAT_W'($past(rbeat_q) + 1'b1));
    a_r6_last_word: assert property (@(posedge clk) disable iff (rst)
        $fell(rvalid) |-> $past(rbeat_q) == BEAT_W'(BURST_LEN - 1));

endmodule

// File: tb/test_qdr_burst_sram.sv
module test_qdr_burst_sram;

    localparam int AW = 4;
    localparam int NB = 2;
    localparam int W  = NB * 8;
    localparam int NBLK = 1 << AW;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           lat_short = 1'b0;
    logic           rd_sel_n = 1'b1;
    logic           wr_sel_n = 1'b1;
    logic [AW-1:0]  addr = '0;
    logic [W-1:0]   wdata = '0;
    logic [NB-1:0]  wbe_n = '1;
    logic [1:0]     slot;
    logic [W-1:0]   rdata;
    logic           rvalid;

    always #10 clk = ~clk;

    qdr_burst_sram #(.AW(AW), .NB(NB)) i_qdr_burst_sram (
        .clk(clk), .rst(rst), .lat_short(lat_short), .rd_sel_n(rd_sel_n),
        .wr_sel_n(wr_sel_n), .addr(addr), .wdata(wdata), .wbe_n(wbe_n),
        .slot(slot), .rdata(rdata), .rvalid(rvalid)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    string tag   = "R11";

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [W-1:0]  m_mem [NBLK*4];
    int            m_slot, m_edge, wseq, m_wseq, m_wa;
    logic          m_wv;
    logic [W-1:0]  m_wd  [4];
    logic [NB-1:0] m_wbe [4];
    int            q_due[$], q_word[$], q_seen[$];
    logic          exp_v;
    logic [W-1:0]  exp_d;
    int            cw;
    bit            cmt;

    function automatic logic [W-1:0] mrg(logic [W-1:0] old, logic [W-1:0] nw, logic [NB-1:0] ben);
        logic [W-1:0] r = old;
        for (int b = 0; b < NB; b++) if (!ben[b]) r[b*8 +: 8] = nw[b*8 +: 8];
        return r;
    endfunction

    initial for (int i = 0; i < NBLK*4; i++) m_mem[i] = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_slot = 0; m_edge = 0; m_wv = 0; wseq = 0; m_wseq = 0; m_wa = 0;
            q_due.delete(); q_word.delete(); q_seen.delete();
            exp_v = 0; exp_d = '0;
        end else begin
            cmt   = (m_slot == 2) && m_wv;
            exp_v = 0;
            if (q_due.size() > 0 && q_due[0] == m_edge) begin
                cw    = q_word[0];
                exp_v = 1;
                exp_d = m_mem[cw];
                if (cmt && m_wseq <= q_seen[0] && cw / 4 == m_wa)
                    exp_d = mrg(exp_d, (cw % 4 == 3) ? wdata : m_wd[cw % 4],
                                (cw % 4 == 3) ? wbe_n : m_wbe[cw % 4]);
                void'(q_due.pop_front()); void'(q_word.pop_front()); void'(q_seen.pop_front());
            end
            if (cmt)
                for (int k = 0; k < 4; k++)
                    m_mem[m_wa*4+k] = mrg(m_mem[m_wa*4+k], (k == 3) ? wdata : m_wd[k],
                                          (k == 3) ? wbe_n : m_wbe[k]);
            if (m_slot == 2) begin
                m_wv = !wr_sel_n;
                m_wa = int'(addr);
                if (!wr_sel_n) begin wseq++; m_wseq = wseq; end
            end else begin
                m_wd[(m_slot+1)%4]  = wdata;
                m_wbe[(m_slot+1)%4] = wbe_n;
            end
            if (m_slot == 0 && !rd_sel_n)
                for (int k = 0; k < 4; k++) begin
                    q_due.push_back(m_edge + (lat_short ? 2 : 3) + k);
                    q_word.push_back(int'(addr)*4 + k);
                    q_seen.push_back(wseq);
                end
            m_slot = (m_slot + 1) % 4;
            m_edge++;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk("R1", "slot", 32'(slot), 32'(m_slot));
            chk(tag, "rvalid", 32'(rvalid), 32'(exp_v));
            chk(tag, "rdata", 32'(rdata), 32'(exp_d));
        end
    end

    // ---------------- stimulus ----------------
    logic [3:0][W-1:0]  pw_d  = '0;
    logic [3:0][NB-1:0] pw_be = '1;

    // Called at a negedge with slot 0 showing; returns at the next such negedge
    task automatic frame(input bit rd, input int ra, input bit wr, input int wa,
                         input logic [3:0][W-1:0] d, input logic [3:0][NB-1:0] be);
        rd_sel_n = !rd; addr = AW'(ra); wdata = pw_d[1]; wbe_n = pw_be[1];
        @(negedge clk);
        rd_sel_n = 1'b1; addr = '0; wdata = pw_d[2]; wbe_n = pw_be[2];
        @(negedge clk);
        wr_sel_n = !wr; addr = AW'(wa); wdata = pw_d[3]; wbe_n = pw_be[3];
        @(negedge clk);
        wr_sel_n = 1'b1; addr = '0; wdata = d[0]; wbe_n = be[0];
        pw_d = d; pw_be = be;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) frame(0, 0, 0, 0, '0, '1);
    endtask

    function automatic logic [3:0][W-1:0] pat(input int blk, input int salt);
        logic [3:0][W-1:0] r;
        for (int k = 0; k < 4; k++) r[k] = W'(blk*4096 + salt*256 + k*17 + 3);
        return r;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", "rvalid in reset", 32'(rvalid), 0);
        chk("R11", "rdata in reset", 32'(rdata), 0);
        chk("R11", "slot in reset", 32'(slot), 0);
        rst = 1'b0;
        tag = "R1";
        idle(2);

        // R3 / R4: fill every block with full enables
        tag = "R3";
        for (int b = 0; b < NBLK; b++) frame(0, 0, 1, b, pat(b, 1), '0);
        idle(2);

        // R4 / R5: full latency, word order, back-to-back reads
        tag = "R4";
        frame(1, 3, 0, 0, '0, '1);
        frame(1, 15, 0, 0, '0, '1);
        frame(1, 0, 0, 0, '0, '1);
        idle(3);

        // R5: short latency
        tag = "R5";
        lat_short = 1'b1;
        frame(1, 7, 0, 0, '0, '1);
        frame(1, 8, 0, 0, '0, '1);
        idle(3);
        lat_short = 1'b0;

        // R2: silent read slot returns nothing
        tag = "R2";
        frame(0, 5, 0, 0, '0, '1);
        idle(2);

        // R3: write with select high leaves block 2 intact
        tag = "R3";
        frame(0, 0, 0, 2, pat(2, 9), '0);
        frame(1, 2, 0, 0, '0, '1);
        idle(3);

        // R8: per-beat byte masks
        tag = "R8";
        frame(0, 0, 1, 4, pat(4, 5), {2'b11, 2'b00, 2'b10, 2'b01});
        idle(1);
        frame(1, 4, 0, 0, '0, '1);
        idle(3);

        // R6: four reads in a row give one unbroken run
        tag = "R6";
        for (int i = 0; i < 4; i++) frame(1, 12 - i, 0, 0, '0, '1);
        idle(3);

        // R7: output held through idle frames
        tag = "R7";
        idle(3);

        // R9: read right after write, full latency
        tag = "R9";
        frame(0, 0, 1, 6, pat(6, 6), '0);
        frame(1, 6, 1, 9, pat(9, 6), '0);
        idle(3);
        // R9: short latency with masks, word 0 meets the commit
        lat_short = 1'b1;
        idle(1);
        frame(0, 0, 1, 10, pat(10, 7), {2'b00, 2'b10, 2'b11, 2'b01});
        frame(1, 10, 0, 0, '0, '1);
        frame(0, 0, 1, 11, pat(11, 7), '0);
        frame(1, 11, 0, 0, '0, '1);
        idle(3);

        // R10: same-frame read and write of one block, both modes
        tag = "R10";
        frame(1, 13, 1, 13, pat(13, 8), '0);
        frame(1, 13, 0, 0, '0, '1);
        idle(3);
        lat_short = 1'b0;
        idle(1);
        frame(1, 14, 1, 14, pat(14, 8), {2'b00, 2'b01, 2'b00, 2'b10});
        frame(1, 14, 1, 1, pat(1, 8), '0);
        frame(1, 1, 0, 0, '0, '1);
        idle(4);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL R6 watchdog expired act=%0d exp=0", 1);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule